// File: doc/BRIEF.md
# Protection Tuple Checker

This block verifies a stream of logical blocks against the 8-byte protection tuple stored with each one. A controller loads a per-command configuration with a `start` pulse: the protection type, where the tuple sits in the metadata, which of the three checks are enabled, the expected application tag and its mask, the first expected reference tag, the low 32 bits of the starting block address, and the block count. The data bytes and then the metadata bytes of every block follow, one byte per accepted cycle.

For each block the checker recomputes a CRC-16 guard over the data and any metadata bytes that precede the tuple. It skips the block when the stored tags carry the escape values. It then compares guard, application tag and reference tag in a fixed priority. The first failing block decides the result. The rest of the stream is swallowed unchecked. A one-cycle `done` strobe presents the status code. A reference-tag mismatch against the block address can be found before any data is sent, and the checker then completes at once.

Top module: `ptc_checker`

## Requirements
- R1: On `start`, if the type is 1, reference checking is enabled, and `cfg_lba_lo` differs from `cfg_ref_tag`, the checker consumes no data. `done` rises in the next cycle with status 1 and `dnr` high. `dnr` is never high with any other status.
- R2: Under types 1 and 2, a stored application tag of 0xFFFF makes the block pass, whatever its guard and reference tag hold.
- R3: Under type 3, a block is skipped only when the stored application tag is 0xFFFF and the stored reference tag is 0xFFFFFFFF. An application tag of 0xFFFF alone does not skip it.
- R4: With the guard check on, the guard is a CRC-16 with polynomial 0x8BB7, initial value 0, MSB first. It covers the block's data bytes and then the metadata bytes ahead of the tuple. A mismatch gives status 2.
- R5: With the application check on, the stored and expected tags are compared only on bits set in `cfg_app_mask`. A mismatch gives status 3.
- R6: With the reference check on, a stored reference tag that differs from the expected one gives status 4.
- R7: The expected reference tag starts at `cfg_ref_tag` and rises by one per block, wrapping at 32 bits, for types other than 3. Under type 3 it stays fixed.
- R8: Within a block, a guard failure outranks an application failure, and an application failure outranks a reference failure. A disabled check never fails.
- R9: The status of the first failing block is reported. Later blocks are consumed without checks, and `done` follows the final byte of the last block.
- R10: The tuple begins at metadata offset 0 when `cfg_first8` is 1, and at offset META_BYTES-8 otherwise. Its layout is guard (bytes 0-1), application tag (bytes 2-3) and reference tag (bytes 4-7), all big-endian. Metadata bytes after the tuple are ignored.
- R11: A byte is consumed only while `in_valid` is high and `busy` is high. Bytes offered while idle have no effect.
- R12: `busy` is high from the cycle after an accepted `start` until the final byte is consumed. `done` is high for exactly the one cycle after that byte, and `busy` is low then.
- R13: During and after reset, `busy`, `done`, `dnr` and `status` are 0. A reset in mid-stream abandons the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Loads the configuration and begins a command (taken while idle) |
| cfg_ptype | input | 2 | Protection type (0 to 3) |
| cfg_first8 | input | 1 | Tuple sits in the first 8 metadata bytes |
| cfg_en_guard | input | 1 | Enable guard check |
| cfg_en_app | input | 1 | Enable application tag check |
| cfg_en_ref | input | 1 | Enable reference tag check |
| cfg_app_tag | input | 16 | Expected application tag |
| cfg_app_mask | input | 16 | Application tag compare mask |
| cfg_ref_tag | input | 32 | Expected reference tag of the first block |
| cfg_lba_lo | input | 32 | Low 32 bits of the starting block address |
| cfg_nblk_m1 | input | NBLK_W | Number of blocks minus one |
| in_valid | input | 1 | Byte on `in_byte` is offered |
| in_byte | input | 8 | Stream byte: data bytes of a block, then its metadata bytes |
| busy | output | 1 | Command in progress, bytes accepted |
| done | output | 1 | One-cycle completion strobe |
| status | output | 3 | 0 ok, 1 invalid protection info, 2 guard, 3 application, 4 reference |
| dnr | output | 1 | Do-not-retry marker, set with status 1 |

## Verification
The hardest cases to reach are a failure in one block followed by different failures in later blocks, and escape tags paired with a bad guard. The stimulus builds correct tuples with a bench-side CRC and then corrupts chosen fields of chosen blocks. One row corrupts the reference tag of block 1 and the guard of every later block, so the reported code proves that the drain does no checking. Escape rows spoil the guard at the same time as they set the escape tags. Other rows put idle gaps in the stream, or start the reference tag at 0xFFFFFFFE so that it wraps.

// File: rtl/ptc_pkg.sv
package ptc_pkg;

   typedef enum logic [2:0] {
      ST_OK    = 3'd0,
      ST_INVPI = 3'd1,
      ST_GUARD = 3'd2,
      ST_APP   = 3'd3,
      ST_REF   = 3'd4
   } ptc_status_e;

   typedef enum logic [1:0] {
      PTC_IDLE,
      PTC_RUN,
      PTC_DRAIN,
      PTC_FIN
   } ptc_state_e;

   // Tuple in stream order: guard first, reference tag last.
   typedef struct packed {
      logic [15:0] guard;
      logic [15:0] app;
      logic [31:0] reftag;
   } ptc_tuple_t;

   localparam int TUPLE_BYTES = 8;

endpackage

// File: rtl/ptc_crc16_step.sv
module ptc_crc16_step #(
   parameter logic [15:0] POLY = 16'h8BB7
) (
   input  logic [15:0] crc_in,
   input  logic [7:0]  byte_in,
   output logic [15:0] crc_out
);
   logic [15:0] stage [0:8];

   assign stage[0] = crc_in ^ {byte_in, 8'h00};

   generate
      for (genvar k = 0; k < 8; k++) begin : g_bit
         assign stage[k+1] = stage[k][15] ? ((stage[k] << 1) ^ POLY)
                                          : (stage[k] << 1);
      end
   endgenerate

   assign crc_out = stage[8];
endmodule

// File: rtl/ptc_tuple_grab.sv
module ptc_tuple_grab
   import ptc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       capture,
   input  logic [2:0] idx,
   input  logic [7:0] byte_in,
   output ptc_tuple_t tuple_nxt
);
   logic [63:0] raw_q;
   logic [63:0] raw_nxt;

   // Byte 0 of the tuple lands in the top byte (big-endian fields).
   always_comb begin
      raw_nxt = raw_q;
      if (capture) raw_nxt[{~idx, 3'b000} +: 8] = byte_in;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) raw_q <= '0;
      else        raw_q <= raw_nxt;
   end

   assign tuple_nxt = ptc_tuple_t'(raw_nxt);
endmodule

// File: rtl/ptc_judge.sv
module ptc_judge
   import ptc_pkg::*;
(
   input  logic [1:0]  ptype,
   input  logic        en_guard,
   input  logic        en_app,
   input  logic        en_ref,
   input  ptc_tuple_t  tup,
   input  logic [15:0] crc,
   input  logic [15:0] exp_app,
   input  logic [15:0] app_mask,
   input  logic [31:0] exp_ref,
   output ptc_status_e verdict
);
   logic skip;

   always_comb begin
      unique case (ptype)
         2'd1, 2'd2: skip = (tup.app == 16'hFFFF);
         2'd3:       skip = (tup.app == 16'hFFFF) && (tup.reftag == 32'hFFFF_FFFF);
         default:    skip = 1'b0;
      endcase
   end

   // Last assignment wins: guard outranks application outranks reference.
   always_comb begin
      verdict = ST_OK;
      if (!skip) begin
         if (en_ref && (tup.reftag != exp_ref))                 verdict = ST_REF;
         if (en_app && (((tup.app ^ exp_app) & app_mask) != '0)) verdict = ST_APP;
         if (en_guard && (tup.guard != crc))                     verdict = ST_GUARD;
      end
   end
endmodule

// File: rtl/ptc_checker.sv
module ptc_checker
   import ptc_pkg::*;
#(
   parameter int          BLK_BYTES  = 512,
   parameter int          META_BYTES = 8,
   parameter int          NBLK_W     = 16,
   parameter logic [15:0] CRC_POLY   = 16'h8BB7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [1:0]        cfg_ptype,
   input  logic              cfg_first8,
   input  logic              cfg_en_guard,
   input  logic              cfg_en_app,
   input  logic              cfg_en_ref,
   input  logic [15:0]       cfg_app_tag,
   input  logic [15:0]       cfg_app_mask,
   input  logic [31:0]       cfg_ref_tag,
   input  logic [31:0]       cfg_lba_lo,
   input  logic [NBLK_W-1:0] cfg_nblk_m1,
   input  logic              in_valid,
   input  logic [7:0]        in_byte,
   output logic              busy,
   output logic              done,
   output logic [2:0]        status,
   output logic              dnr
);
   localparam int FRAME_BYTES = BLK_BYTES + META_BYTES;
   localparam int POS_W       = $clog2(FRAME_BYTES);
   localparam int LATE_BASE   = META_BYTES - TUPLE_BYTES;

   generate
      if (META_BYTES < TUPLE_BYTES) begin : g_bad_meta
         $error("META_BYTES must hold the 8-byte tuple");
      end
      if (BLK_BYTES < 1) begin : g_bad_blk
         $error("BLK_BYTES must be at least 1");
      end
      if (NBLK_W < 1) begin : g_bad_cnt
         $error("NBLK_W must be at least 1");
      end
   endgenerate

   ptc_state_e        state_q;
   ptc_status_e       status_q;
   ptc_status_e       verdict;
   logic [1:0]        ptype_q;
   logic              first8_q, en_guard_q, en_app_q, en_ref_q;
   logic [15:0]       app_q, mask_q;
   logic [31:0]       exp_ref_q;
   logic [NBLK_W-1:0] left_q;
   logic [POS_W-1:0]  pos_q;
   logic [15:0]       crc_q, crc_nxt;
   ptc_tuple_t        tuple_nxt;

   logic              accept, checking, last_byte, in_data, in_pre, in_tup;
   logic              feed_crc, capture, addr_bad;
   logic [POS_W-1:0]  meta_off, tup_base, tup_rel;

   assign accept    = in_valid && ((state_q == PTC_RUN) || (state_q == PTC_DRAIN));
   assign checking  = (state_q == PTC_RUN);
   assign last_byte = (pos_q == POS_W'(FRAME_BYTES - 1));
   assign in_data   = (pos_q < POS_W'(BLK_BYTES));
   assign meta_off  = pos_q - POS_W'(BLK_BYTES);
   assign tup_base  = first8_q ? '0 : POS_W'(LATE_BASE);
   assign tup_rel   = meta_off - tup_base;
   assign in_pre    = !in_data && (meta_off < tup_base);
   assign in_tup    = !in_data && (meta_off >= tup_base) && (tup_rel < POS_W'(TUPLE_BYTES));
   assign feed_crc  = accept && checking && (in_data || in_pre);
   assign capture   = accept && checking && in_tup;
   assign addr_bad  = (cfg_ptype == 2'd1) && cfg_en_ref && (cfg_lba_lo != cfg_ref_tag);

   ptc_crc16_step #(.POLY(CRC_POLY)) u_crc (
      .crc_in  (crc_q),
      .byte_in (in_byte),
      .crc_out (crc_nxt)
   );

   ptc_tuple_grab u_grab (
      .clk       (clk),
      .rst_n     (rst_n),
      .capture   (capture),
      .idx       (tup_rel[2:0]),
      .byte_in   (in_byte),
      .tuple_nxt (tuple_nxt)
   );

   ptc_judge u_judge (
      .ptype    (ptype_q),
      .en_guard (en_guard_q),
      .en_app   (en_app_q),
      .en_ref   (en_ref_q),
      .tup      (tuple_nxt),
      .crc      (crc_q),
      .exp_app  (app_q),
      .app_mask (mask_q),
      .exp_ref  (exp_ref_q),
      .verdict  (verdict)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= PTC_IDLE;
         status_q   <= ST_OK;
         ptype_q    <= '0;
         first8_q   <= 1'b0;
         en_guard_q <= 1'b0;
         en_app_q   <= 1'b0;
         en_ref_q   <= 1'b0;
         app_q      <= '0;
         mask_q     <= '0;
         exp_ref_q  <= '0;
         left_q     <= '0;
         pos_q      <= '0;
         crc_q      <= '0;
      end else begin
         unique case (state_q)
            PTC_IDLE: begin
               if (start) begin
                  ptype_q    <= cfg_ptype;
                  first8_q   <= cfg_first8;
                  en_guard_q <= cfg_en_guard;
                  en_app_q   <= cfg_en_app;
                  en_ref_q   <= cfg_en_ref;
                  app_q      <= cfg_app_tag;
                  mask_q     <= cfg_app_mask;
                  exp_ref_q  <= cfg_ref_tag;
                  left_q     <= cfg_nblk_m1;
                  pos_q      <= '0;
                  crc_q      <= '0;
                  status_q   <= addr_bad ? ST_INVPI : ST_OK;
                  state_q    <= addr_bad ? PTC_FIN : PTC_RUN;
               end
            end
            PTC_RUN, PTC_DRAIN: begin
               if (accept) begin
                  if (feed_crc) crc_q <= crc_nxt;
                  if (last_byte) begin
                     pos_q <= '0;
                     crc_q <= '0;
                     if (left_q == '0) begin
                        state_q <= PTC_FIN;
                     end else begin
                        left_q <= left_q - 1'b1;
                        if (checking && (verdict != ST_OK)) state_q <= PTC_DRAIN;
                     end
                     if (checking) begin
                        if (verdict != ST_OK)     status_q  <= verdict;
                        else if (ptype_q != 2'd3) exp_ref_q <= exp_ref_q + 32'd1;
                     end
                  end else begin
                     pos_q <= pos_q + 1'b1;
                  end
               end
            end
            PTC_FIN: state_q <= PTC_IDLE;
            default: state_q <= PTC_IDLE;
         endcase
      end
   end

   assign busy   = (state_q == PTC_RUN) || (state_q == PTC_DRAIN);
   assign done   = (state_q == PTC_FIN);
   assign status = status_q;
   assign dnr    = done && (status_q == ST_INVPI);
endmodule

// File: rtl/ptc_checker_chk.sv
module ptc_checker_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       start,
   input logic       busy,
   input logic       done,
   input logic [2:0] status,
   input logic       dnr
);
   // R12
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R12
   done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R1
   dnr_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dnr |-> (done && status == 3'd1));

   // R1
   dnr_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dnr |-> $past(start));

   // R9
   status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && status != 3'd0) |=> (status == $past(status)));

   // R12
   done_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> ($past(busy) || $past(start)));

   // R13
   status_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      status <= 3'd4);
endmodule

bind ptc_checker ptc_checker_chk u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .start  (start),
   .busy   (busy),
   .done   (done),
   .status (status),
   .dnr    (dnr)
);

// File: tb/ptc_checker_tb_top.sv
`timescale 1ns/1ps
module ptc_checker_tb_top;
   localparam int BLK   = 8;
   localparam int META  = 16;
   localparam int FRAME = BLK + META;
   localparam int NBW   = 4;

   // corruption kinds
   localparam int K_NONE = 0, K_GUARD = 1, K_APP = 2, K_REF = 3, K_ESCA = 4,
                  K_ESCB = 5, K_ALL = 6, K_AR = 7, K_FIRST = 8, K_META = 9, K_PRE = 10;

   typedef struct packed {
      logic [1:0]  ptype;
      logic        f8;
      logic [2:0]  en;    // [2] guard, [1] app, [0] ref
      logic [15:0] app;
      logic [15:0] mask;
      logic [31:0] rtag;
      logic [31:0] lba;
      logic [3:0]  nbm1;
      logic [3:0]  cb;
      logic [3:0]  kind;
      logic [2:0]  exp;
   } vec_t;

   localparam int NV = 21;
   localparam vec_t VECS [NV] = '{
      '{2'd1,1'b0,3'b111,16'h1234,16'hFFFF,32'h100,32'h100,4'd3,4'd0,4'd0,3'd0},             // 0  R4 R6 R7 R10 clean
      '{2'd1,1'b1,3'b111,16'h1234,16'hFFFF,32'h200,32'h200,4'd3,4'd2,4'd1,3'd2},             // 1  R4 R10 guard, tuple first
      '{2'd2,1'b0,3'b111,16'hABCD,16'hFFFF,32'h5,32'h0,4'd2,4'd1,4'd2,3'd3},                 // 2  R5 app mismatch
      '{2'd2,1'b0,3'b111,16'hABCD,16'hFFFE,32'h5,32'h0,4'd2,4'd1,4'd2,3'd0},                 // 3  R5 masked-out bit
      '{2'd1,1'b0,3'b111,16'h1234,16'hFFFF,32'h10,32'h10,4'd3,4'd3,4'd3,3'd4},               // 4  R6 R7 ref error
      '{2'd3,1'b0,3'b111,16'h5555,16'hFFFF,32'h77,32'h999,4'd3,4'd0,4'd0,3'd0},              // 5  R7 type 3 constant
      '{2'd3,1'b0,3'b111,16'h5555,16'hFFFF,32'h77,32'h999,4'd1,4'd0,4'd4,3'd2},              // 6  R3 app escape alone
      '{2'd3,1'b1,3'b111,16'h5555,16'hFFFF,32'h77,32'h999,4'd1,4'd0,4'd5,3'd0},              // 7  R3 both escapes
      '{2'd1,1'b0,3'b111,16'h1234,16'hFFFF,32'h40,32'h40,4'd2,4'd1,4'd4,3'd0},               // 8  R2 type 1
      '{2'd2,1'b1,3'b111,16'h1234,16'hFFFF,32'h40,32'h40,4'd2,4'd0,4'd4,3'd0},               // 9  R2 type 2
      '{2'd1,1'b0,3'b111,16'h1234,16'hFFFF,32'h300,32'h300,4'd0,4'd0,4'd6,3'd2},             // 10 R8 all bad
      '{2'd1,1'b0,3'b111,16'h1234,16'hFFFF,32'h300,32'h300,4'd0,4'd0,4'd7,3'd3},             // 11 R8 app+ref bad
      '{2'd1,1'b0,3'b001,16'h1234,16'hFFFF,32'h300,32'h300,4'd0,4'd0,4'd6,3'd4},             // 12 R8 only ref on
      '{2'd1,1'b0,3'b000,16'h1234,16'hFFFF,32'h300,32'h300,4'd0,4'd0,4'd6,3'd0},             // 13 R8 all off
      '{2'd1,1'b0,3'b111,16'h1234,16'hFFFF,32'h100,32'h1,4'd0,4'd0,4'd0,3'd1},               // 14 R1 address mismatch
      '{2'd1,1'b0,3'b110,16'h1234,16'hFFFF,32'h100,32'h1,4'd0,4'd0,4'd0,3'd0},               // 15 R1 ref off
      '{2'd1,1'b0,3'b111,16'h1234,16'hFFFF,32'hFFFF_FFFE,32'hFFFF_FFFE,4'd3,4'd0,4'd0,3'd0}, // 16 R7 wrap
      '{2'd1,1'b0,3'b111,16'h1234,16'hFFFF,32'h50,32'h50,4'd3,4'd1,4'd8,3'd4},               // 17 R9 first failure wins
      '{2'd1,1'b1,3'b111,16'h1234,16'hFFFF,32'h60,32'h60,4'd1,4'd0,4'd9,3'd0},               // 18 R10 trailing meta ignored
      '{2'd1,1'b0,3'b111,16'h1234,16'hFFFF,32'h70,32'h70,4'd1,4'd1,4'd10,3'd2},              // 19 R4 pre-tuple meta in CRC
      '{2'd1,1'b0,3'b111,16'h1234,16'hFFFF,32'h80,32'h80,4'd3,4'd3,4'd6,3'd2}                // 20 R9 failure in last block
   };

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic           rst_n, start, cfg_first8, cfg_en_guard, cfg_en_app, cfg_en_ref, in_valid;
   logic [1:0]     cfg_ptype;
   logic [15:0]    cfg_app_tag, cfg_app_mask;
   logic [31:0]    cfg_ref_tag, cfg_lba_lo;
   logic [NBW-1:0] cfg_nblk_m1;
   logic [7:0]     in_byte;
   logic           busy, done, dnr;
   logic [2:0]     status;

   ptc_checker #(.BLK_BYTES(BLK), .META_BYTES(META), .NBLK_W(NBW)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .cfg_ptype(cfg_ptype),
      .cfg_first8(cfg_first8), .cfg_en_guard(cfg_en_guard), .cfg_en_app(cfg_en_app),
      .cfg_en_ref(cfg_en_ref), .cfg_app_tag(cfg_app_tag), .cfg_app_mask(cfg_app_mask),
      .cfg_ref_tag(cfg_ref_tag), .cfg_lba_lo(cfg_lba_lo), .cfg_nblk_m1(cfg_nblk_m1),
      .in_valid(in_valid), .in_byte(in_byte), .busy(busy), .done(done),
      .status(status), .dnr(dnr)
   );

   int checks = 0;
   int fails  = 0;

   task automatic chk(input bit ok, input string what, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   function automatic logic [15:0] crc_upd(input logic [15:0] c, input logic [7:0] b);
      logic [15:0] x;
      x = c ^ {b, 8'h00};
      for (int k = 0; k < 8; k++) x = x[15] ? ((x << 1) ^ 16'h8BB7) : (x << 1);
      return x;
   endfunction

   task automatic send_frame(input int v, input int b, input vec_t t, input bit gaps);
      logic [7:0]  fr [FRAME];
      logic [15:0] g;
      logic [15:0] a;
      logic [31:0] r;
      int          tb;
      int          kd;
      tb = t.f8 ? 0 : META - 8;
      kd = int'(t.kind);
      g  = 16'h0000;
      for (int i = 0; i < BLK; i++) begin
         fr[i] = 8'(v * 37 + b * 11 + i * 5 + 3);
         g     = crc_upd(g, fr[i]);
      end
      for (int m = 0; m < META; m++) fr[BLK+m] = 8'(v * 13 + b * 7 + m * 3 + 1);
      for (int m = 0; m < tb; m++) g = crc_upd(g, fr[BLK+m]);
      a = t.app;
      r = (t.ptype == 2'd3) ? t.rtag : t.rtag + 32'(b);
      if (b == int'(t.cb)) begin
         case (kd)
            K_GUARD: g ^= 16'h0001;
            K_APP:   a ^= 16'h0001;
            K_REF:   r ^= 32'h1;
            K_ESCA:  begin a = 16'hFFFF; g ^= 16'h0001; end
            K_ESCB:  begin a = 16'hFFFF; r = 32'hFFFF_FFFF; g ^= 16'h0001; end
            K_ALL:   begin g ^= 16'h0001; a ^= 16'h0001; r ^= 32'h1; end
            K_AR:    begin a ^= 16'h0001; r ^= 32'h1; end
            K_FIRST: r ^= 32'h1;
            default: ;
         endcase
      end
      if (kd == K_FIRST && b > int'(t.cb)) g ^= 16'h0001;
      fr[BLK+tb+0] = g[15:8];
      fr[BLK+tb+1] = g[7:0];
      fr[BLK+tb+2] = a[15:8];
      fr[BLK+tb+3] = a[7:0];
      fr[BLK+tb+4] = r[31:24];
      fr[BLK+tb+5] = r[23:16];
      fr[BLK+tb+6] = r[15:8];
      fr[BLK+tb+7] = r[7:0];
      if (b == int'(t.cb) && kd == K_PRE)  fr[BLK] ^= 8'h01;
      if (b == int'(t.cb) && kd == K_META) fr[FRAME-1] ^= 8'h80;
      for (int i = 0; i < FRAME; i++) begin
         in_valid = 1'b1;
         in_byte  = fr[i];
         @(negedge clk);
         if (gaps && (i % 5 == 4) && (i != FRAME - 1)) begin
            in_valid = 1'b0;
            in_byte  = 8'hA5;   // R11 garbage while invalid
            @(negedge clk);
         end
      end
      in_valid = 1'b0;
   endtask

   task automatic load_cfg(input vec_t t);
      cfg_ptype    = t.ptype;
      cfg_first8   = t.f8;
      cfg_en_guard = t.en[2];
      cfg_en_app   = t.en[1];
      cfg_en_ref   = t.en[0];
      cfg_app_tag  = t.app;
      cfg_app_mask = t.mask;
      cfg_ref_tag  = t.rtag;
      cfg_lba_lo   = t.lba;
      cfg_nblk_m1  = t.nbm1;
   endtask

   task automatic run_vec(input int v, input bit gaps);
      vec_t t;
      t = VECS[v];
      load_cfg(t);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (t.exp == 3'd1) begin
         chk(done === 1'b1, $sformatf("R1 vector %0d immediate done", v), longint'(done), 1);
         chk(status == 3'd1, $sformatf("R1 vector %0d status", v), longint'(status), 1);
         chk(dnr === 1'b1, $sformatf("R1 vector %0d dnr", v), longint'(dnr), 1);
         chk(busy === 1'b0, $sformatf("R1 vector %0d no stream taken", v), longint'(busy), 0);
      end else begin
         chk(busy === 1'b1 && done === 1'b0, $sformatf("R12 vector %0d busy after start", v),
             longint'({busy, done}), 2);
         for (int b = 0; b <= int'(t.nbm1); b++) send_frame(v, b, t, gaps);
         chk(done === 1'b1, $sformatf("R12 vector %0d done after final byte", v), longint'(done), 1);
         chk(status == t.exp, $sformatf("vector %0d status (see row comment)", v),
             longint'(status), longint'(t.exp));
         chk(dnr === 1'b0, $sformatf("R1 vector %0d dnr clear", v), longint'(dnr), 0);
      end
      @(negedge clk);
      chk(done === 1'b0 && busy === 1'b0, $sformatf("R12 vector %0d done one cycle", v),
          longint'({busy, done}), 0);
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (60000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      rst_n = 1'b0; start = 1'b0; in_valid = 1'b0; in_byte = 8'h00;
      load_cfg(VECS[0]);
      repeat (3) @(negedge clk);
      // R13 reset state
      chk({busy, done, dnr, status} == 6'b0, "R13 outputs in reset", longint'({busy, done, dnr, status}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk({busy, done, dnr, status} == 6'b0, "R13 outputs after reset", longint'({busy, done, dnr, status}), 0);

      // R11 bytes offered while idle do nothing
      for (int i = 0; i < 6; i++) begin
         in_valid = 1'b1;
         in_byte  = 8'(i * 29);
         @(negedge clk);
         chk(busy === 1'b0 && done === 1'b0, "R11 idle bytes ignored", longint'({busy, done}), 0);
      end
      in_valid = 1'b0;
      run_vec(0, 1'b0);

      for (int v = 0; v < NV; v++) run_vec(v, (v % 3) == 1);

      // R13 reset in mid-stream abandons the command
      load_cfg(VECS[4]);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int i = 0; i < 10; i++) begin
         in_valid = 1'b1;
         in_byte  = 8'(i);
         @(negedge clk);
      end
      in_valid = 1'b0;
      rst_n    = 1'b0;
      @(negedge clk);
      chk({busy, done, status} == 5'b0, "R13 mid-stream reset", longint'({busy, done, status}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      run_vec(4, 1'b0);

      finish_run();
   end
endmodule